// File: doc/BRIEF.md
# CMI Line Encoder with NRZ Bypass

This block turns a serial NRZ bit stream into Coded Mark Inversion (CMI) line symbols. It runs on a clock at twice the NRZ bit rate, so one clock cycle is one half-bit. A bit-rate strobe marks the cycles in which an NRZ bit is presented. Each bit accepted in coding mode leaves the block as a two-half-bit word. A zero always becomes low-then-high. A one becomes either two low half-bits or two high half-bits, and the choice flips with each coded one.

A low-active mode input chooses between CMI coding and plain NRZ pass-through. In pass-through the bit is held on the output for the whole bit period. The output clock enable then pulses once per bit instead of once per half-bit. The mode is sampled together with each bit, so a mode change never splits a code word.

The producer must leave at least one idle cycle between strobes. Each accepted bit occupies two output cycles.

Top module: `cmi_line_encoder`

## Requirements
- R1: While reset is held and after its release, `line_out` and `line_ce` are 0. The running polarity is set so that the first coded one becomes 00.
- R2: In coding mode (`code_n`=0) an NRZ zero is emitted as half-bits 0 then 1.
- R3: In coding mode successive ones are emitted alternately as 0,0 and 1,1. The first one after reset gives 0,0.
- R4: The one-polarity is held across coded zeros and across bits sent in pass-through mode. Only coded ones flip it.
- R5: A bit captured at a clock edge with `bit_en`=1 shows its first half-bit on `line_out` right after that edge. Its second half-bit follows one clock later.
- R6: In coding mode `line_ce` is 1 during both half-bit cycles of every word.
- R7: In pass-through mode (`code_n`=1) `line_out` equals the bit in both cycles of its period. `line_ce` is 1 only in the first cycle.
- R8: `code_n` is sampled only with `bit_en`=1. A change during the second half of a word does not alter that half or its `line_ce`.
- R9: When no bit follows a finished word, `line_ce` is 0 and `line_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Strobe: an NRZ bit is present this cycle |
| nrz_in | input | 1 | NRZ data bit |
| code_n | input | 1 | 0 = CMI coding, 1 = NRZ pass-through |
| line_out | output | 1 | Registered line half-bit |
| line_ce | output | 1 | Output clock enable |

## Verification
The hardest state to reach from the ports is a one-polarity carried over a long stretch where ones are not being coded. That covers strings of zeros and, above all, ones sent in pass-through between coded ones. The stimulus interleaves coded ones with zeros and with bypassed ones, and checks that the next coded one takes the opposite level of the previous coded one. A second awkward case is a mode change placed exactly in the second half of a word. The bench flips `code_n` in that cycle only and checks the remaining half-bit.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
    localparam int HALVES = 2;
    typedef logic [HALVES-1:0] cmi_word_t;  // [1] first half, [0] second half

    typedef struct packed {
        logic out;      // current line half-bit
        logic pend;     // second half-bit waiting
        logic pend_v;   // second half-bit valid
        logic ce;       // output clock enable
        logic coding;   // mode of the word in flight
    } shift_st_t;
endpackage

// File: rtl/cmi_polarity_track.sv
module cmi_polarity_track #(
    parameter logic POL_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic pol
);
    logic pol_d, pol_q;

    always_comb begin
        pol_d = pol_q;
        if (adv) pol_d = ~pol_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= POL_INIT;
        else        pol_q <= pol_d;
    end

    assign pol = pol_q;

    // R3: every coded one flips the polarity
    a_r3_flip_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (pol_q != $past(pol_q)));
    // R4: polarity held when no coded one is seen
    a_r4_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pol_q));
endmodule

// File: rtl/cmi_symbol_map.sv
module cmi_symbol_map
    import cmi_pkg::*;
(
    input  logic      bit_in,
    input  logic      pol,
    input  logic      coding,
    output cmi_word_t word
);
    always_comb begin
        if (!coding)     word = {bit_in, bit_in};
        else if (!bit_in) word = 2'b01;
        else             word = {pol, pol};
    end
endmodule

// File: rtl/cmi_half_shifter.sv
module cmi_half_shifter
    import cmi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      coding,
    input  cmi_word_t word,
    output logic      out,
    output logic      ce
);
    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.out    = word[1];
            st_d.pend   = word[0];
            st_d.pend_v = 1'b1;
            st_d.ce     = 1'b1;
            st_d.coding = coding;
        end else if (st_q.pend_v) begin
            st_d.out    = st_q.pend;
            st_d.pend_v = 1'b0;
            st_d.ce     = st_q.coding;
        end else begin
            st_d.ce     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out = st_q.out;
    assign ce  = st_q.ce;

    // R6: a coded word keeps the clock enable on for its second half
    a_r6_coded_second_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (load && coding) |=> ##1 ce);
    // R7: a bypassed bit gives no enable in its second cycle
    a_r7_bypass_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !coding) |=> ##1 !ce);
    // R9: with no pending half and no load the line holds
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !st_q.pend_v) |=> ($stable(out) && !ce));
endmodule

// File: rtl/cmi_line_encoder.sv
module cmi_line_encoder
    import cmi_pkg::*;
#(
    parameter logic POL_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic nrz_in,
    input  logic code_n,
    output logic line_out,
    output logic line_ce
);
    logic      coding;
    logic      pol;
    logic      pol_adv;
    cmi_word_t word;

    assign coding  = ~code_n;
    assign pol_adv = bit_en & nrz_in & coding;

    cmi_polarity_track #(.POL_INIT(POL_INIT)) u_pol (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pol_adv),
        .pol   (pol)
    );

    cmi_symbol_map u_map (
        .bit_in (nrz_in),
        .pol    (pol),
        .coding (coding),
        .word   (word)
    );

    cmi_half_shifter u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bit_en),
        .coding (coding),
        .word   (word),
        .out    (line_out),
        .ce     (line_ce)
    );

    // R5: every captured bit raises the enable in the next cycle
    a_r5_ce_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> line_ce);
    // R2: coded zero starts low
    a_r2_zero_first_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !code_n && !nrz_in) |=> !line_out);
    // R2: coded zero ends high
    a_r2_zero_second_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !code_n && !nrz_in) |=> ##1 line_out);
    // R7: bypassed bit appears unchanged
    a_r7_bypass_value: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && code_n) |=> (line_out == $past(nrz_in)));
    // R1: outputs idle during reset
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (!line_ce || $isunknown(line_ce));
        end
    end
endmodule

// File: tb/tb_cmi_line_encoder.sv
module tb_cmi_line_encoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic nrz_in = 1'b0;
    logic code_n = 1'b0;
    logic line_out, line_ce;

    int total = 0;
    int bad = 0;
    logic model_pol = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    cmi_line_encoder dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .nrz_in(nrz_in),
        .code_n(code_n), .line_out(line_out), .line_ce(line_ce)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drives one bit at a negedge, samples both half-bit cycles at negedges
    task automatic send_bit(input logic b, output logic h1, output logic c1,
                            output logic h2, output logic c2);
        bit_en = 1'b1; nrz_in = b;
        @(posedge clk); @(negedge clk);
        h1 = line_out; c1 = line_ce;
        bit_en = 1'b0;
        @(posedge clk); @(negedge clk);
        h2 = line_out; c2 = line_ce;
    endtask

    task automatic coded_bit(input logic b, input string tag);
        logic h1, c1, h2, c2, e1, e2;
        if (!b) begin e1 = 1'b0; e2 = 1'b1; end
        else begin e1 = model_pol; e2 = model_pol; model_pol = ~model_pol; end
        send_bit(b, h1, c1, h2, c2);
        check({tag, " first half"}, h1, e1);
        check({tag, " second half"}, h2, e2);
        check("R6 ce first", c1, 1'b1);
        check("R6 ce second", c2, 1'b1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 line_out in reset", line_out, 1'b0);
        check("R1 line_ce in reset", line_ce, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 line_ce after release", line_ce, 1'b0);
        check("R1 line_out after release", line_out, 1'b0);
    endtask

    task automatic t_zeros;
        code_n = 1'b0;
        for (int i = 0; i < 4; i++) coded_bit(1'b0, "R2 zero");
    endtask

    task automatic t_ones;
        code_n = 1'b0;
        for (int i = 0; i < 4; i++) coded_bit(1'b1, "R3 one");
    endtask

    task automatic t_mixed;
        code_n = 1'b0;
        coded_bit(1'b1, "R3 one");
        coded_bit(1'b0, "R4 zero between");
        coded_bit(1'b0, "R4 zero between");
        coded_bit(1'b1, "R4 one after zeros");
        coded_bit(1'b0, "R2 zero");
        coded_bit(1'b1, "R4 one after zero");
    endtask

    task automatic t_latency;
        logic h1, c1, h2, c2;
        logic e;
        code_n = 1'b0;
        e = model_pol;
        bit_en = 1'b1; nrz_in = 1'b1;
        @(posedge clk); #1;
        check("R5 ce right after capture", line_ce, 1'b1);
        check("R5 first half right after capture", line_out, e);
        bit_en = 1'b0;
        @(negedge clk);
        @(posedge clk); #1;
        check("R5 second half one cycle later", line_out, e);
        model_pol = ~model_pol;
        @(negedge clk);
        h1 = 0; c1 = 0; h2 = 0; c2 = 0;
        send_bit(1'b1, h1, c1, h2, c2);
        check("R5 next one opposite", h1, model_pol);
        model_pol = ~model_pol;
    endtask

    task automatic t_bypass;
        logic h1, c1, h2, c2;
        code_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            logic b;
            b = (i == 1) ? 1'b0 : 1'b1;
            send_bit(b, h1, c1, h2, c2);
            check("R7 bypass first", h1, b);
            check("R7 bypass second", h2, b);
            check("R7 bypass ce first", c1, 1'b1);
            check("R7 bypass ce second", c2, 1'b0);
        end
        code_n = 1'b0;
        coded_bit(1'b1, "R4 one after bypassed ones");
    endtask

    task automatic t_midword;
        logic h1, c1, h2, c2;
        // coded zero, switch to bypass during second half
        code_n = 1'b0;
        bit_en = 1'b1; nrz_in = 1'b0;
        @(posedge clk); @(negedge clk);
        h1 = line_out;
        bit_en = 1'b0; code_n = 1'b1;
        @(posedge clk); @(negedge clk);
        h2 = line_out; c2 = line_ce;
        check("R8 first half kept", h1, 1'b0);
        check("R8 second half kept", h2, 1'b1);
        check("R8 ce kept coded", c2, 1'b1);
        // bypassed one, switch to coding during second half
        bit_en = 1'b1; nrz_in = 1'b1;
        @(posedge clk); @(negedge clk);
        h1 = line_out;
        bit_en = 1'b0; code_n = 1'b0;
        @(posedge clk); @(negedge clk);
        h2 = line_out; c2 = line_ce;
        check("R8 bypass first", h1, 1'b1);
        check("R8 bypass second kept", h2, 1'b1);
        check("R8 bypass ce kept", c2, 1'b0);
        coded_bit(1'b1, "R8 coding resumes");
    endtask

    task automatic t_idle;
        logic last;
        code_n = 1'b0;
        coded_bit(1'b0, "R2 zero before idle");
        last = line_out;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 idle ce", line_ce, 1'b0);
            check("R9 idle hold", line_out, last);
        end
    endtask

    initial begin
        t_reset();
        t_zeros();
        t_ones();
        t_mixed();
        t_latency();
        t_bypass();
        t_midword();
        t_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule